// File: doc/BRIEF.md
# Serial Programming Command Slave

This block is the target side of a four-byte serial programming link. An external programmer drives a serial clock and a data line into the block while holding the target's active-low reset low. The block samples each data bit on the rising edge of the serial clock, most significant bit first, and puts its own reply bit out after each falling edge. Each frame holds four bytes: an operation code, an upper and a lower address byte, and a data byte. The block decodes each frame and acts on its own models of the nonvolatile storage: a 16-bit word program array, a byte-wide data EEPROM, three read-only signature bytes and two active-low protection bits.

A state machine sequences the session. In `ST_OFF` the target reset is released and the link does nothing. Pulling reset low moves it to `ST_SYNC` (transition *reset_asserted*). There the reply line is not driven and every frame except the enable frame is ignored. A complete enable frame moves it to `ST_OPEN` (transition *enable_frame*). In `ST_OPEN` reads, writes, protection changes and erase are carried out. An erase frame moves it to `ST_ERASE` (transition *erase_frame*). There the storage is swept back to its blank state and all frames are ignored. Every state goes back to `ST_OFF` when reset is released (transition *reset_released*). This is the only way to leave `ST_ERASE`.

The system clock `clk` oversamples the serial pins. `por_n` is the power-on reset of the storage model, which starts blank.

Top module: `isp_prog_slave`

## Requirements
- R1: A frame is four bytes. Bits are taken on rising edges of `sck` and sent after falling edges, most significant bit first. The first reply byte of every frame is 0x00.
- R2: In reply bytes two, three and four, the block returns the byte it received just before, unless R5, R7 or R8 supply read data in byte four.
- R3: While `tgt_rst_n` is high, the link is idle and `miso_oe` is 0. After `tgt_rst_n` falls, every frame other than the enable frame (0xAC, 0x53, any, any) is ignored, and no storage changes.
- R4: `miso_oe` stays 0 until a complete enable frame has been received. It then stays 1 until `tgt_rst_n` is released.
- R5: Opcode 0x20 returns the low byte and 0x28 returns the high byte (opcode bit 3 picks the high byte) of program word {byte2,byte3} modulo the array depth. The value comes back in reply byte four.
- R6: Opcode 0x60 writes the low byte and 0x68 writes the high byte of the addressed word. The stored byte becomes the old byte ANDed with the data byte.
- R7: Opcode 0xA0 reads and 0xC0 writes EEPROM byte {byte2,byte3} modulo its depth. A write replaces the byte.
- R8: Opcode 0x30 returns a signature byte chosen by bits [1:0] of byte 3: 0 gives 0x1E, 1 gives 0x90, 2 gives 0x01, 3 gives 0xFF.
- R9: The protection frame 0xAC with byte 2 of the form 11111ba1 clears protection bit 1 when a=0 and protection bit 2 when b=0 (0xFD clears bit 1). Bits can only be cleared. While bit 1 is 0, program and EEPROM writes have no effect.
- R10: While both protection bits are 0, every read (R5, R7, R8) returns byte 3 of its frame. Clearing bit 2 alone changes neither reads nor writes.
- R11: An erase frame (0xAC, 0x8X) sets every program word to 0xFFFF and every EEPROM byte to 0xFF. Only after the sweep has finished are both protection bits set back to 1. All later frames are ignored until `tgt_rst_n` is released, and access must then be enabled again.
- R12: After power-on reset, every program word reads 0xFFFF, every EEPROM byte reads 0xFF and neither protection bit is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| por_n | input | 1 | Active-low power-on reset of the link and the storage model |
| tgt_rst_n | input | 1 | Target reset, active low; programming is possible while low |
| sck | input | 1 | Serial clock from the programmer |
| mosi | input | 1 | Serial data from the programmer |
| miso | output | 1 | Serial reply data |
| miso_oe | output | 1 | Drive enable for the reply line |

## Verification
Directed frames cover each path in turn: a write attempted before enable, the enable frame, each signature index, overlapping AND-writes to one word, and address aliasing above the array depth. They also walk the protection bits in the order bit 2 alone, then bit 1, then both, and finish with an erase, frames sent during the erase, and a reset release. The directed frames tell true storage behaviour apart from plain echo. A fixed-seed random run mixes reads and writes of both arrays at full 16-bit addresses. Its results are compared with a bench model, which separates correct address wrapping and byte-lane selection from stale or crossed data.

// File: rtl/isp_pkg.sv
package isp_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_SYNC  = 2'd1,
        ST_OPEN  = 2'd2,
        ST_ERASE = 2'd3
    } isp_state_e;

    localparam logic [7:0] OP_FL_RD_LO = 8'h20;
    localparam logic [7:0] OP_FL_RD_HI = 8'h28;
    localparam logic [7:0] OP_FL_WR_LO = 8'h60;
    localparam logic [7:0] OP_FL_WR_HI = 8'h68;
    localparam logic [7:0] OP_EE_RD    = 8'hA0;
    localparam logic [7:0] OP_EE_WR    = 8'hC0;
    localparam logic [7:0] OP_SIG_RD   = 8'h30;
    localparam logic [7:0] OP_CONTROL  = 8'hAC;
    localparam logic [7:0] KEY_ENABLE  = 8'h53;

endpackage

// File: rtl/isp_pin_sync.sv
module isp_pin_sync (
    input  logic clk,
    input  logic por_n,
    input  logic sck,
    input  logic mosi,
    input  logic tgt_rst_n,
    output logic sck_rise,
    output logic sck_fall,
    output logic mosi_s,
    output logic prog_mode
);
    logic [2:0] sck_q;
    logic [1:0] mosi_q;
    logic [1:0] rst_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            sck_q  <= '0;
            mosi_q <= '0;
            rst_q  <= 2'b11;
        end else begin
            sck_q  <= {sck_q[1:0], sck};
            mosi_q <= {mosi_q[0], mosi};
            rst_q  <= {rst_q[0], tgt_rst_n};
        end
    end

    // mosi_q[1] is aligned with sck_q[1]
    assign sck_rise  = sck_q[1] & ~sck_q[2];
    assign sck_fall  = ~sck_q[1] & sck_q[2];
    assign mosi_s    = mosi_q[1];
    assign prog_mode = ~rst_q[1];

endmodule

// File: rtl/isp_byte_shifter.sv
module isp_byte_shifter (
    input  logic       clk,
    input  logic       por_n,
    input  logic       clear,
    input  logic       sck_rise,
    input  logic       sck_fall,
    input  logic       mosi_s,
    input  logic [7:0] tx_val,
    output logic       byte_end,
    output logic [1:0] byte_pos,
    output logic [7:0] rx_next,
    output logic       miso_d
);
    logic [2:0] bit_cnt;
    logic [6:0] rx_q;
    logic [7:0] tx_q;
    logic [1:0] pos_q;

    assign rx_next  = {rx_q, mosi_s};
    assign byte_end = sck_rise && (bit_cnt == 3'd7);
    assign byte_pos = pos_q;
    assign miso_d   = tx_q[7];

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            bit_cnt <= '0;
            rx_q    <= '0;
            tx_q    <= '0;
            pos_q   <= '0;
        end else if (clear) begin
            bit_cnt <= '0;
            rx_q    <= '0;
            tx_q    <= '0;
            pos_q   <= '0;
        end else if (sck_rise) begin
            rx_q    <= rx_next[6:0];
            bit_cnt <= bit_cnt + 3'd1;
            if (byte_end) begin
                tx_q  <= tx_val;
                pos_q <= pos_q + 2'd1;
            end
        end else if (sck_fall && (bit_cnt != 3'd0)) begin
            tx_q <= {tx_q[6:0], 1'b0};
        end
    end

    // R1: byte position only advances at the end of a byte
    p_pos_steady_r1: assert property (@(posedge clk) disable iff (!por_n)
        (!byte_end && !clear) |=> $stable(pos_q));

    // R1: the reply bit holds still across a rising edge of the serial clock
    p_reply_stable_r1: assert property (@(posedge clk) disable iff (!por_n)
        (sck_rise && !byte_end && !clear) |=> $stable(miso_d));

endmodule

// File: rtl/isp_nvm_model.sv
module isp_nvm_model #(
    parameter int FL_WORDS = 64,
    parameter int EE_BYTES = 64
) (
    input  logic        clk,
    input  logic        por_n,
    input  logic        fl_we,
    input  logic        fl_hi,
    input  logic        ee_we,
    input  logic [15:0] wr_addr,
    input  logic [7:0]  wdata,
    input  logic [15:0] rd_addr,
    input  logic        lock_we,
    input  logic [1:0]  lock_mask,
    input  logic        erase_go,
    output logic [15:0] fl_rd_word,
    output logic [7:0]  ee_rd_byte,
    output logic [1:0]  lock_n,
    output logic        erase_busy
);
    localparam int FL_AW = $clog2(FL_WORDS);
    localparam int EE_AW = $clog2(EE_BYTES);
    localparam int SWEEP = (FL_WORDS > EE_BYTES) ? FL_WORDS : EE_BYTES;
    localparam int CW    = $clog2(SWEEP) + 1;

    logic [15:0]   flash [FL_WORDS];
    logic [7:0]    eep   [EE_BYTES];
    logic [CW-1:0] sweep_cnt;
    logic [FL_AW-1:0] fl_wi, fl_ri;
    logic [EE_AW-1:0] ee_wi, ee_ri;

    assign fl_wi = FL_AW'(wr_addr % FL_WORDS);
    assign fl_ri = FL_AW'(rd_addr % FL_WORDS);
    assign ee_wi = EE_AW'(wr_addr % EE_BYTES);
    assign ee_ri = EE_AW'(rd_addr % EE_BYTES);

    assign fl_rd_word = flash[fl_ri];
    assign ee_rd_byte = eep[ee_ri];

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            for (int i = 0; i < FL_WORDS; i++) flash[i] <= 16'hFFFF;
            for (int j = 0; j < EE_BYTES; j++) eep[j] <= 8'hFF;
            lock_n     <= 2'b11;
            erase_busy <= 1'b0;
            sweep_cnt  <= '0;
        end else if (erase_go) begin
            erase_busy <= 1'b1;
            sweep_cnt  <= '0;
        end else if (erase_busy) begin
            if (int'(sweep_cnt) < FL_WORDS) flash[FL_AW'(sweep_cnt)] <= 16'hFFFF;
            if (int'(sweep_cnt) < EE_BYTES) eep[EE_AW'(sweep_cnt)] <= 8'hFF;
            sweep_cnt <= sweep_cnt + 1'b1;
            if (int'(sweep_cnt) == SWEEP - 1) begin
                erase_busy <= 1'b0;
                lock_n     <= 2'b11;
            end
        end else begin
            if (fl_we) begin
                if (fl_hi) flash[fl_wi][15:8] <= flash[fl_wi][15:8] & wdata;
                else       flash[fl_wi][7:0]  <= flash[fl_wi][7:0] & wdata;
            end
            if (ee_we)   eep[ee_wi] <= wdata;
            if (lock_we) lock_n <= lock_n & lock_mask;
        end
    end

    // R9: no write request reaches storage while write protection is on
    p_write_locked_r9: assert property (@(posedge clk) disable iff (!por_n)
        (fl_we || ee_we) |-> lock_n[0]);

    // R11: protection is lifted only at the end of an erase sweep
    p_lock_release_r11: assert property (@(posedge clk) disable iff (!por_n)
        $rose(lock_n[0]) |-> $past(erase_busy));

    // R11: no write request during the erase sweep
    p_no_write_erase_r11: assert property (@(posedge clk) disable iff (!por_n)
        erase_busy |-> (!fl_we && !ee_we && !lock_we));

endmodule

// File: rtl/isp_cmd_ctrl.sv
module isp_cmd_ctrl
    import isp_pkg::*;
#(
    parameter logic [7:0] SIG0 = 8'h1E,
    parameter logic [7:0] SIG1 = 8'h90,
    parameter logic [7:0] SIG2 = 8'h01
) (
    input  logic        clk,
    input  logic        por_n,
    input  logic        prog_mode,
    input  logic        byte_end,
    input  logic [1:0]  byte_pos,
    input  logic [7:0]  rx_next,
    input  logic [15:0] fl_rd_word,
    input  logic [7:0]  ee_rd_byte,
    input  logic [1:0]  lock_n,
    output logic        clear,
    output logic [7:0]  tx_val,
    output logic        miso_oe,
    output logic        fl_we,
    output logic        fl_hi,
    output logic        ee_we,
    output logic [15:0] wr_addr,
    output logic [7:0]  wdata,
    output logic [15:0] rd_addr,
    output logic        lock_we,
    output logic [1:0]  lock_mask,
    output logic        erase_go
);
    isp_state_e state, state_nxt;
    logic [7:0] op_q, ah_q, al_q;
    logic       frame_done, is_enable, is_erase, is_lock, is_read, do_exec;
    logic [7:0] mem_byte;

    assign frame_done = byte_end && (byte_pos == 2'd3);
    assign is_enable  = (op_q == OP_CONTROL) && (ah_q == KEY_ENABLE);
    assign is_erase   = (op_q == OP_CONTROL) && (ah_q[7:4] == 4'h8);
    assign is_lock    = (op_q == OP_CONTROL) && (ah_q[7:3] == 5'b11111) && ah_q[0];
    assign is_read    = (op_q == OP_FL_RD_LO) || (op_q == OP_FL_RD_HI) ||
                        (op_q == OP_EE_RD)    || (op_q == OP_SIG_RD);

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_OFF:   if (prog_mode) state_nxt = ST_SYNC;                 // reset_asserted
            ST_SYNC:  if (frame_done && is_enable) state_nxt = ST_OPEN;   // enable_frame
            ST_OPEN:  if (frame_done && is_erase) state_nxt = ST_ERASE;   // erase_frame
            ST_ERASE: state_nxt = ST_ERASE;
        endcase
        if (!prog_mode) state_nxt = ST_OFF;                               // reset_released
    end

    // state register and frame byte capture
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state <= ST_OFF;
            op_q  <= '0;
            ah_q  <= '0;
            al_q  <= '0;
        end else begin
            state <= state_nxt;
            if (byte_end) begin
                unique case (byte_pos)
                    2'd0: op_q <= rx_next;
                    2'd1: ah_q <= rx_next;
                    2'd2: al_q <= rx_next;
                    2'd3: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        unique case (op_q)
            OP_FL_RD_LO: mem_byte = fl_rd_word[7:0];
            OP_FL_RD_HI: mem_byte = fl_rd_word[15:8];
            OP_EE_RD:    mem_byte = ee_rd_byte;
            default: begin
                unique case (rx_next[1:0])
                    2'd0: mem_byte = SIG0;
                    2'd1: mem_byte = SIG1;
                    2'd2: mem_byte = SIG2;
                    2'd3: mem_byte = 8'hFF;
                endcase
            end
        endcase

        unique case (byte_pos)
            2'd0, 2'd1: tx_val = rx_next;
            2'd2: begin
                if ((state == ST_OPEN) && is_read && (lock_n != 2'b00)) tx_val = mem_byte;
                else                                                   tx_val = rx_next;
            end
            2'd3: tx_val = 8'h00;
        endcase

        clear     = (state == ST_OFF);
        miso_oe   = (state == ST_OPEN) || (state == ST_ERASE);
        do_exec   = frame_done && (state == ST_OPEN);
        fl_we     = do_exec && lock_n[0] && ((op_q == OP_FL_WR_LO) || (op_q == OP_FL_WR_HI));
        fl_hi     = op_q[3];
        ee_we     = do_exec && lock_n[0] && (op_q == OP_EE_WR);
        lock_we   = do_exec && is_lock;
        lock_mask = ah_q[2:1];
        erase_go  = do_exec && is_erase;
        wr_addr   = {ah_q, al_q};
        wdata     = rx_next;
        rd_addr   = {ah_q, rx_next};
    end

    // R4: the reply line opens only after an enable frame
    p_oe_after_enable_r4: assert property (@(posedge clk) disable iff (!por_n)
        $rose(miso_oe) |-> ($past(op_q) == OP_CONTROL) && ($past(ah_q) == KEY_ENABLE));

    // R3: the reply line closes only when target reset is released
    p_oe_close_r3: assert property (@(posedge clk) disable iff (!por_n)
        $fell(miso_oe) |-> !$past(prog_mode));

    // R11: the erase state is left only through reset release
    p_erase_hold_r11: assert property (@(posedge clk) disable iff (!por_n)
        (state == ST_ERASE && prog_mode) |=> (state == ST_ERASE));

endmodule

// File: rtl/isp_prog_slave.sv
module isp_prog_slave #(
    parameter int         FL_WORDS = 64,
    parameter int         EE_BYTES = 64,
    parameter logic [7:0] SIG0     = 8'h1E,
    parameter logic [7:0] SIG1     = 8'h90,
    parameter logic [7:0] SIG2     = 8'h01
) (
    input  logic clk,
    input  logic por_n,
    input  logic tgt_rst_n,
    input  logic sck,
    input  logic mosi,
    output logic miso,
    output logic miso_oe
);
    logic        sck_rise, sck_fall, mosi_s, prog_mode;
    logic        clear, byte_end;
    logic [1:0]  byte_pos;
    logic [7:0]  rx_next, tx_val, wdata, ee_rd_byte;
    logic [15:0] wr_addr, rd_addr, fl_rd_word;
    logic        fl_we, fl_hi, ee_we, lock_we, erase_go, erase_busy;
    logic [1:0]  lock_mask, lock_n;

    isp_pin_sync u_sync (
        .clk(clk), .por_n(por_n), .sck(sck), .mosi(mosi), .tgt_rst_n(tgt_rst_n),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_s(mosi_s), .prog_mode(prog_mode)
    );

    isp_byte_shifter u_shift (
        .clk(clk), .por_n(por_n), .clear(clear), .sck_rise(sck_rise), .sck_fall(sck_fall),
        .mosi_s(mosi_s), .tx_val(tx_val), .byte_end(byte_end), .byte_pos(byte_pos),
        .rx_next(rx_next), .miso_d(miso)
    );

    isp_cmd_ctrl #(.SIG0(SIG0), .SIG1(SIG1), .SIG2(SIG2)) u_ctrl (
        .clk(clk), .por_n(por_n), .prog_mode(prog_mode), .byte_end(byte_end),
        .byte_pos(byte_pos), .rx_next(rx_next), .fl_rd_word(fl_rd_word),
        .ee_rd_byte(ee_rd_byte), .lock_n(lock_n), .clear(clear), .tx_val(tx_val),
        .miso_oe(miso_oe), .fl_we(fl_we), .fl_hi(fl_hi), .ee_we(ee_we),
        .wr_addr(wr_addr), .wdata(wdata), .rd_addr(rd_addr), .lock_we(lock_we),
        .lock_mask(lock_mask), .erase_go(erase_go)
    );

    isp_nvm_model #(.FL_WORDS(FL_WORDS), .EE_BYTES(EE_BYTES)) u_nvm (
        .clk(clk), .por_n(por_n), .fl_we(fl_we), .fl_hi(fl_hi), .ee_we(ee_we),
        .wr_addr(wr_addr), .wdata(wdata), .rd_addr(rd_addr), .lock_we(lock_we),
        .lock_mask(lock_mask), .erase_go(erase_go), .fl_rd_word(fl_rd_word),
        .ee_rd_byte(ee_rd_byte), .lock_n(lock_n), .erase_busy(erase_busy)
    );

endmodule

// File: tb/isp_prog_slave_test.sv
module isp_prog_slave_test;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;
    localparam int DEPTH      = 64;

    logic clk = 0, por_n = 0, tgt_rst_n = 1, sck = 0, mosi = 0;
    logic miso, miso_oe;
    int checks = 0, failures = 0;
    bit done = 0;

    // bench model: 0 off, 1 sync, 2 open, 3 erase
    logic [15:0] m_fl [DEPTH];
    logic [7:0]  m_ee [DEPTH];
    logic        m_lb1, m_lb2;
    int          m_st;

    always #(CLK_PERIOD/2) clk = ~clk;

    isp_prog_slave uut (
        .clk(clk), .por_n(por_n), .tgt_rst_n(tgt_rst_n), .sck(sck), .mosi(mosi),
        .miso(miso), .miso_oe(miso_oe)
    );

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic xfer_byte(input logic [7:0] d, output logic [7:0] q);
        for (int i = 7; i >= 0; i--) begin
            mosi = d[i];
            repeat (HALF) @(negedge clk);
            q[i] = miso;
            sck = 1;
            repeat (HALF) @(negedge clk);
            sck = 0;
        end
    endtask

    function automatic logic [7:0] read_val(input logic [7:0] op, input logic [7:0] al);
        logic [5:0] ix = al[5:0];
        if (!m_lb1 && !m_lb2) return al;
        case (op)
            8'h20: return m_fl[ix][7:0];
            8'h28: return m_fl[ix][15:8];
            8'hA0: return m_ee[ix];
            default: case (al[1:0])
                2'd0: return 8'h1E;
                2'd1: return 8'h90;
                2'd2: return 8'h01;
                default: return 8'hFF;
            endcase
        endcase
    endfunction

    function automatic string tag_of(input logic [7:0] op);
        case (op)
            8'h20, 8'h28: return "R5";
            8'h60, 8'h68: return "R6";
            8'hA0, 8'hC0: return "R7";
            8'h30: return "R8";
            default: return "R2";
        endcase
    endfunction

    task automatic frame(input logic [7:0] b1, b2, b3, b4, input string tag);
        logic [7:0] r0, r1, r2, r3, exp4;
        int st0 = m_st;
        bit rd = (b1 == 8'h20) || (b1 == 8'h28) || (b1 == 8'hA0) || (b1 == 8'h30);
        exp4 = (st0 == 2 && rd) ? read_val(b1, b3) : b3;
        xfer_byte(b1, r0);
        xfer_byte(b2, r1);
        xfer_byte(b3, r2);
        xfer_byte(b4, r3);
        if (st0 >= 2) begin
            chk({8'h0, r0}, 16'h0, "R1 first reply byte");
            chk({8'h0, r1}, {8'h0, b1}, "R2 echo byte2");
            chk({8'h0, r2}, {8'h0, b2}, "R2 echo byte3");
            chk({8'h0, r3}, {8'h0, exp4}, tag);
        end
        // model update
        if (st0 == 1 && b1 == 8'hAC && b2 == 8'h53) m_st = 2;
        else if (st0 == 2) begin
            if ((b1 == 8'h60 || b1 == 8'h68) && m_lb1) begin
                if (b1[3]) m_fl[b3[5:0]][15:8] = m_fl[b3[5:0]][15:8] & b4;
                else       m_fl[b3[5:0]][7:0]  = m_fl[b3[5:0]][7:0] & b4;
            end
            if (b1 == 8'hC0 && m_lb1) m_ee[b3[5:0]] = b4;
            if (b1 == 8'hAC && b2[7:3] == 5'b11111 && b2[0]) begin
                m_lb1 = m_lb1 & b2[1];
                m_lb2 = m_lb2 & b2[2];
            end
            if (b1 == 8'hAC && b2[7:4] == 4'h8) begin
                for (int k = 0; k < DEPTH; k++) begin
                    m_fl[k] = 16'hFFFF;
                    m_ee[k] = 8'hFF;
                end
                m_lb1 = 1; m_lb2 = 1; m_st = 3;
            end
        end
        repeat (12) @(negedge clk);
        chk({15'h0, miso_oe}, {15'h0, (m_st >= 2)}, "R4 reply enable");
    endtask

    task automatic set_rst(input logic v);
        tgt_rst_n = v;
        repeat (10) @(negedge clk);
        m_st = v ? 0 : 1;
        chk({15'h0, miso_oe}, 16'h0, "R3 reply disabled after reset edge");
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        logic [7:0] ops [6];
        seed = $urandom(32'd20240611);
        ops = '{8'h20, 8'h28, 8'h60, 8'h68, 8'hA0, 8'hC0};
        for (int k = 0; k < DEPTH; k++) begin
            m_fl[k] = 16'hFFFF;
            m_ee[k] = 8'hFF;
        end
        m_lb1 = 1; m_lb2 = 1; m_st = 0;
        repeat (5) @(negedge clk);
        por_n = 1;
        repeat (5) @(negedge clk);
        chk({15'h0, miso_oe}, 16'h0, "R4 reset state");

        set_rst(1'b0);
        // R3: frames before enable are ignored
        frame(8'h60, 8'h00, 8'h07, 8'h00, "R3");
        frame(8'hC0, 8'h00, 8'h07, 8'h00, "R3");
        frame(8'hAC, 8'h53, 8'h00, 8'h00, "R4");
        frame(8'h20, 8'h00, 8'h07, 8'h00, "R3 pre-enable write ignored");
        frame(8'hA0, 8'h00, 8'h07, 8'h00, "R3 pre-enable write ignored");
        frame(8'h28, 8'h00, 8'h21, 8'h00, "R12 blank program word");
        // R8 signature
        for (int a = 0; a < 4; a++) frame(8'h30, 8'h5A, 8'(a), 8'h00, "R8");
        // R5 / R6 program writes with AND behaviour
        frame(8'h60, 8'h01, 8'h04, 8'h01, "R6");
        frame(8'h68, 8'h01, 8'h04, 8'h0F, "R6");
        frame(8'h20, 8'h01, 8'h04, 8'h00, "R5 low byte");
        frame(8'h28, 8'h01, 8'h04, 8'h00, "R5 high byte");
        frame(8'h60, 8'h00, 8'h04, 8'hF0, "R6");
        frame(8'h20, 8'h00, 8'h04, 8'h00, "R6 AND of old and new");
        // R7 EEPROM with aliasing above depth
        frame(8'hC0, 8'h00, 8'h11, 8'h0F, "R7");
        frame(8'hA0, 8'h00, 8'h51, 8'h00, "R7 alias read");
        frame(8'hC0, 8'h02, 8'h11, 8'hA5, "R7");
        frame(8'hA0, 8'h00, 8'h11, 8'h00, "R7 overwrite");
        // random mix
        for (int n = 0; n < 140; n++) begin
            logic [7:0] op = ops[$urandom % 6];
            frame(op, 8'($urandom), 8'($urandom), 8'($urandom), tag_of(op));
        end
        // R10: bit 2 alone has no effect
        frame(8'hAC, 8'hFB, 8'h00, 8'h00, "R9");
        frame(8'hC0, 8'h00, 8'h09, 8'h3C, "R10 bit2 alone write");
        frame(8'hA0, 8'h00, 8'h09, 8'h00, "R10 bit2 alone read");
        frame(8'h68, 8'h00, 8'h05, 8'h12, "R10 bit2 alone write");
        // R9: write protection
        frame(8'hAC, 8'hFD, 8'h00, 8'h00, "R9");
        frame(8'hC0, 8'h00, 8'h09, 8'h00, "R9 write blocked");
        frame(8'hA0, 8'h00, 8'h09, 8'h00, "R9 write blocked");
        frame(8'h60, 8'h00, 8'h05, 8'h00, "R9 write blocked");
        frame(8'h20, 8'h00, 8'h05, 8'h00, "R9 write blocked");
        // R10: both bits clear
        frame(8'hAC, 8'hF9, 8'h00, 8'h00, "R9");
        frame(8'hA0, 8'h00, 8'h09, 8'h00, "R10 read returns address");
        frame(8'h28, 8'h00, 8'h05, 8'h00, "R10 read returns address");
        frame(8'h30, 8'h00, 8'h02, 8'h00, "R10 read returns address");
        // R11 erase
        frame(8'hAC, 8'h80, 8'h00, 8'h00, "R11");
        repeat (200) @(negedge clk);
        frame(8'h20, 8'h00, 8'h05, 8'h00, "R11 ignored during erase");
        frame(8'hC0, 8'h00, 8'h09, 8'h00, "R11 ignored during erase");
        set_rst(1'b1);
        set_rst(1'b0);
        frame(8'h20, 8'h00, 8'h05, 8'h00, "R11 not open before enable");
        frame(8'hAC, 8'h53, 8'h00, 8'h00, "R4");
        frame(8'h28, 8'h00, 8'h05, 8'h00, "R11 erased word");
        frame(8'hA0, 8'h00, 8'h09, 8'h00, "R11 erased eeprom");
        frame(8'hC0, 8'h00, 8'h09, 8'h66, "R11 locks released");
        frame(8'hA0, 8'h00, 8'h09, 8'h00, "R11 locks released");
        set_rst(1'b1);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule